// File: doc/BRIEF.md
# AXI Outstanding-Limit and Latency Shaper

This block sits on an AXI link between a manager and a subordinate and makes the subordinate look slower and narrower than it is. It counts read transactions and write transactions in flight. It holds back new address handshakes whenever a read cap, a write cap or a shared read-plus-write cap would be passed. It also holds every read-data and write-response handshake until a minimum number of cycles has passed for that transaction. All caps and latencies are elaboration-time parameters, so one instance can model a fast local memory and another a slow, mostly-read backing store.

Each accepted transaction takes a slot in a per-direction ring, kept in issue order, with its own down-counting timer. A read timer starts at the address handshake. A write timer starts at the first accepted data beat of that write. The head slot's response passes only once its timer reaches zero. Payload fields pass through unchanged, and responses are assumed to return in issue order.

Top module: `axi_txn_shaper`

## Requirements
- R1: Accepting a read address never brings pending reads above RD_MAX, counted before any completion in the same cycle. RD_MAX = 0 means no read cap, and reads are then bounded by SLOTS. A read is pending from its address handshake until the handshake of its beat with rlast set.
- R2: Accepting a write address never brings pending writes above WR_MAX, or above SLOTS when WR_MAX = 0. A write is pending from its address handshake until its response handshake.
- R3: Accepting addresses never brings pending reads plus pending writes above ALL_MAX (0 = no cap, then 2*SLOTS). When both directions compete for the last shared slot, the read is granted. With requests on both sides, the subordinate always ready and no responses returned, the counts settle at min(RD cap, ALL_MAX) reads, with writes filling the rest of ALL_MAX.
- R4: A read beat is offered upstream exactly when the subordinate offers it, a read is pending, and at least RD_LAT+1 cycles have passed since the cycle whose closing edge accepted the oldest pending read's address. The same condition applies to every beat of the burst.
- R5: A write response is offered upstream exactly when the subordinate offers it, a write is pending, and at least WR_LAT+1 cycles have passed since the cycle whose closing edge accepted the first data beat of the oldest pending write.
- R6: A write-data beat passes in either direction only while some accepted write address still awaits its last data beat: up_wready equals dn_wready in that state and is 0 otherwise.
- R7: Once an address is offered downstream and not accepted, it stays offered with the same address on the next cycle while the manager keeps it valid.
- R8: Addresses, lengths, data, strobes, last flags and response codes pass through unchanged. The k-th read burst or write response upstream belongs to the k-th accepted address of that direction.
- R9: After reset nothing is pending. No response is offered upstream, no write data is accepted, and up_arready follows dn_arready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_arvalid | input | 1 | Read address valid from manager |
| up_arready | output | 1 | Read address ready to manager |
| up_araddr | input | ADDR_W | Read address |
| up_arlen | input | 8 | Read burst length minus one |
| dn_arvalid | output | 1 | Read address valid to subordinate |
| dn_arready | input | 1 | Read address ready from subordinate |
| dn_araddr | output | ADDR_W | Forwarded read address |
| dn_arlen | output | 8 | Forwarded read length |
| dn_rvalid | input | 1 | Read data valid from subordinate |
| dn_rready | output | 1 | Read data ready to subordinate |
| dn_rdata | input | DATA_W | Read data from subordinate |
| dn_rresp | input | 2 | Read response from subordinate |
| dn_rlast | input | 1 | Last read beat from subordinate |
| up_rvalid | output | 1 | Read data valid to manager |
| up_rready | input | 1 | Read data ready from manager |
| up_rdata | output | DATA_W | Read data to manager |
| up_rresp | output | 2 | Read response to manager |
| up_rlast | output | 1 | Last read beat to manager |
| up_awvalid | input | 1 | Write address valid from manager |
| up_awready | output | 1 | Write address ready to manager |
| up_awaddr | input | ADDR_W | Write address |
| up_awlen | input | 8 | Write burst length minus one |
| dn_awvalid | output | 1 | Write address valid to subordinate |
| dn_awready | input | 1 | Write address ready from subordinate |
| dn_awaddr | output | ADDR_W | Forwarded write address |
| dn_awlen | output | 8 | Forwarded write length |
| up_wvalid | input | 1 | Write data valid from manager |
| up_wready | output | 1 | Write data ready to manager |
| up_wdata | input | DATA_W | Write data |
| up_wstrb | input | DATA_W/8 | Write byte strobes |
| up_wlast | input | 1 | Last write beat |
| dn_wvalid | output | 1 | Write data valid to subordinate |
| dn_wready | input | 1 | Write data ready from subordinate |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_wstrb | output | DATA_W/8 | Forwarded strobes |
| dn_wlast | output | 1 | Forwarded last flag |
| dn_bvalid | input | 1 | Write response valid from subordinate |
| dn_bready | output | 1 | Write response ready to subordinate |
| dn_bresp | input | 2 | Write response code from subordinate |
| up_bvalid | output | 1 | Write response valid to manager |
| up_bready | input | 1 | Write response ready from manager |
| up_bresp | output | 2 | Write response code to manager |

## Verification
A single read with an always-ready subordinate that answers at once shows whether the read timer releases on exactly the expected cycle rather than early or late. A saturation pattern offers addresses on both sides every cycle while no responses come back; the counts it leaves show that the read cap, the unlimited write cap and the shared cap interact with read priority. Long random traffic varies the ready and valid rates on every channel and issues write data ahead of its address. This separates correct cap accounting, burst-wide release, data gating and in-order pairing from designs that release on the wrong slot, start the write timer at the wrong event or let a waiting address drop.

// File: rtl/axi_txn_shaper.sv
module axi_txn_shaper #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int RD_MAX  = 4,
  parameter int WR_MAX  = 4,
  parameter int ALL_MAX = 8,
  parameter int RD_LAT  = 50,
  parameter int WR_LAT  = 50,
  parameter int SLOTS   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_arvalid,
  output logic                up_arready,
  input  logic [ADDR_W-1:0]   up_araddr,
  input  logic [7:0]          up_arlen,
  output logic                dn_arvalid,
  input  logic                dn_arready,
  output logic [ADDR_W-1:0]   dn_araddr,
  output logic [7:0]          dn_arlen,
  input  logic                dn_rvalid,
  output logic                dn_rready,
  input  logic [DATA_W-1:0]   dn_rdata,
  input  logic [1:0]          dn_rresp,
  input  logic                dn_rlast,
  output logic                up_rvalid,
  input  logic                up_rready,
  output logic [DATA_W-1:0]   up_rdata,
  output logic [1:0]          up_rresp,
  output logic                up_rlast,
  input  logic                up_awvalid,
  output logic                up_awready,
  input  logic [ADDR_W-1:0]   up_awaddr,
  input  logic [7:0]          up_awlen,
  output logic                dn_awvalid,
  input  logic                dn_awready,
  output logic [ADDR_W-1:0]   dn_awaddr,
  output logic [7:0]          dn_awlen,
  input  logic                up_wvalid,
  output logic                up_wready,
  input  logic [DATA_W-1:0]   up_wdata,
  input  logic [DATA_W/8-1:0] up_wstrb,
  input  logic                up_wlast,
  output logic                dn_wvalid,
  input  logic                dn_wready,
  output logic [DATA_W-1:0]   dn_wdata,
  output logic [DATA_W/8-1:0] dn_wstrb,
  output logic                dn_wlast,
  input  logic                dn_bvalid,
  output logic                dn_bready,
  input  logic [1:0]          dn_bresp,
  output logic                up_bvalid,
  input  logic                up_bready,
  output logic [1:0]          up_bresp
);
  localparam int PW      = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SW      = $clog2(2*SLOTS + 2);
  localparam int RD_EFF  = (RD_MAX == 0 || RD_MAX > SLOTS) ? SLOTS : RD_MAX;
  localparam int WR_EFF  = (WR_MAX == 0 || WR_MAX > SLOTS) ? SLOTS : WR_MAX;
  localparam int ALL_EFF = (ALL_MAX == 0 || ALL_MAX > 2*SLOTS) ? 2*SLOTS : ALL_MAX;
  localparam int LMAX    = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int TW      = $clog2(LMAX + 2);
  localparam logic [SW-1:0] RD_LIM  = SW'(RD_EFF);
  localparam logic [SW-1:0] WR_LIM  = SW'(WR_EFF);
  localparam logic [SW-1:0] ALL_LIM = SW'(ALL_EFF);
  localparam logic [TW-1:0] RD_LD   = TW'(RD_LAT);
  localparam logic [TW-1:0] WR_LD   = TW'(WR_LAT);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [SW-1:0] rd_cnt, wr_cnt, wd_cnt;
  logic [PW-1:0] rd_wp, rd_rp, wr_wp, wr_dp, wr_bp;
  logic          ar_held, aw_held, w_first;
  logic [TW-1:0] rt [SLOTS];
  logic [TW-1:0] wt [SLOTS];
  logic          warm [SLOTS];

  wire [SW-1:0] tot     = rd_cnt + wr_cnt;
  wire          rd_ok   = ar_held | ((rd_cnt < RD_LIM) && (tot + SW'(aw_held) < ALL_LIM));
  wire          ar_take = up_arvalid & rd_ok;
  wire          wr_ok   = aw_held | ((wr_cnt < WR_LIM) && (tot + SW'(ar_take) < ALL_LIM));
  wire          aw_take = up_awvalid & wr_ok;
  wire          ar_hs   = ar_take & dn_arready;
  wire          aw_hs   = aw_take & dn_awready;

  wire rd_open = (rd_cnt != '0) && (rt[rd_rp] == '0);
  wire w_open  = (wd_cnt != '0);
  wire b_open  = (wr_cnt != '0) && warm[wr_bp] && (wt[wr_bp] == '0);

  assign dn_arvalid = ar_take;
  assign up_arready = dn_arready & rd_ok;
  assign dn_araddr  = up_araddr;
  assign dn_arlen   = up_arlen;
  assign dn_awvalid = aw_take;
  assign up_awready = dn_awready & wr_ok;
  assign dn_awaddr  = up_awaddr;
  assign dn_awlen   = up_awlen;

  assign up_rvalid  = dn_rvalid & rd_open;
  assign dn_rready  = up_rready & rd_open;
  assign up_rdata   = dn_rdata;
  assign up_rresp   = dn_rresp;
  assign up_rlast   = dn_rlast;

  assign dn_wvalid  = up_wvalid & w_open;
  assign up_wready  = dn_wready & w_open;
  assign dn_wdata   = up_wdata;
  assign dn_wstrb   = up_wstrb;
  assign dn_wlast   = up_wlast;

  assign up_bvalid  = dn_bvalid & b_open;
  assign dn_bready  = up_bready & b_open;
  assign up_bresp   = dn_bresp;

  wire r_done = up_rvalid & up_rready & dn_rlast;
  wire w_hs   = dn_wvalid & dn_wready;
  wire w_end  = w_hs & up_wlast;
  wire b_hs   = up_bvalid & up_bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0; wr_cnt <= '0; wd_cnt <= '0;
      rd_wp <= '0; rd_rp <= '0; wr_wp <= '0; wr_dp <= '0; wr_bp <= '0;
      ar_held <= 1'b0; aw_held <= 1'b0; w_first <= 1'b1;
    end else begin
      rd_cnt  <= rd_cnt + SW'(ar_hs) - SW'(r_done);
      wr_cnt  <= wr_cnt + SW'(aw_hs) - SW'(b_hs);
      wd_cnt  <= wd_cnt + SW'(aw_hs) - SW'(w_end);
      if (ar_hs)  rd_wp <= nxt(rd_wp);
      if (r_done) rd_rp <= nxt(rd_rp);
      if (aw_hs)  wr_wp <= nxt(wr_wp);
      if (w_end)  wr_dp <= nxt(wr_dp);
      if (b_hs)   wr_bp <= nxt(wr_bp);
      ar_held <= ar_take & ~dn_arready;
      aw_held <= aw_take & ~dn_awready;
      if (w_hs) w_first <= up_wlast;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             rt[i] <= '0;
      else if (ar_hs && rd_wp == PW'(i))      rt[i] <= RD_LD;
      else if (rt[i] != '0)                   rt[i] <= rt[i] - 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wt[i] <= '0;
        warm[i] <= 1'b0;
      end else if (w_hs && w_first && wr_dp == PW'(i)) begin
        wt[i] <= WR_LD;
        warm[i] <= 1'b1;
      end else begin
        if (warm[i] && wt[i] != '0) wt[i] <= wt[i] - 1'b1;
        if (b_hs && wr_bp == PW'(i)) warm[i] <= 1'b0;
      end
    end
  end
endmodule

module axi_txn_shaper_chk #(
  parameter int RD_MAX  = 4,
  parameter int WR_MAX  = 4,
  parameter int ALL_MAX = 8,
  parameter int SLOTS   = 8
) (
  input logic clk,
  input logic rst_n,
  input logic up_arvalid,
  input logic dn_arvalid,
  input logic dn_arready,
  input logic up_awvalid,
  input logic dn_awvalid,
  input logic dn_awready,
  input logic up_rvalid,
  input logic up_rready,
  input logic up_rlast,
  input logic up_bvalid,
  input logic up_bready,
  input logic dn_wvalid,
  input logic dn_wready,
  input logic dn_wlast
);
  localparam int RD_EFF  = (RD_MAX == 0 || RD_MAX > SLOTS) ? SLOTS : RD_MAX;
  localparam int WR_EFF  = (WR_MAX == 0 || WR_MAX > SLOTS) ? SLOTS : WR_MAX;
  localparam int ALL_EFF = (ALL_MAX == 0 || ALL_MAX > 2*SLOTS) ? 2*SLOTS : ALL_MAX;

  logic [15:0] cr, cw, cwd;
  wire ar_hs = dn_arvalid & dn_arready;
  wire aw_hs = dn_awvalid & dn_awready;
  wire r_end = up_rvalid & up_rready & up_rlast;
  wire b_end = up_bvalid & up_bready;
  wire w_end = dn_wvalid & dn_wready & dn_wlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr <= '0; cw <= '0; cwd <= '0;
    end else begin
      cr  <= cr + 16'(ar_hs) - 16'(r_end);
      cw  <= cw + 16'(aw_hs) - 16'(b_end);
      cwd <= cwd + 16'(aw_hs) - 16'(w_end);
    end
  end

  a_r1_rd_cap: assert property (@(posedge clk) disable iff (!rst_n) cr <= 16'(RD_EFF));
  a_r2_wr_cap: assert property (@(posedge clk) disable iff (!rst_n) cw <= 16'(WR_EFF));
  a_r3_all_cap: assert property (@(posedge clk) disable iff (!rst_n) (cr + cw) <= 16'(ALL_EFF));
  a_r4_r_owed: assert property (@(posedge clk) disable iff (!rst_n) up_rvalid |-> cr != '0);
  a_r5_b_owed: assert property (@(posedge clk) disable iff (!rst_n) up_bvalid |-> cw != '0);
  a_r6_w_gate: assert property (@(posedge clk) disable iff (!rst_n) dn_wvalid |-> cwd != '0);
  a_r7_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_arvalid && !dn_arready) |=> (dn_arvalid || !up_arvalid));
  a_r7_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_awvalid && !dn_awready) |=> (dn_awvalid || !up_awvalid));
endmodule

bind axi_txn_shaper axi_txn_shaper_chk #(
  .RD_MAX(RD_MAX), .WR_MAX(WR_MAX), .ALL_MAX(ALL_MAX), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .up_arvalid(up_arvalid), .dn_arvalid(dn_arvalid), .dn_arready(dn_arready),
  .up_awvalid(up_awvalid), .dn_awvalid(dn_awvalid), .dn_awready(dn_awready),
  .up_rvalid(up_rvalid), .up_rready(up_rready), .up_rlast(up_rlast),
  .up_bvalid(up_bvalid), .up_bready(up_bready),
  .dn_wvalid(dn_wvalid), .dn_wready(dn_wready), .dn_wlast(dn_wlast)
);

// File: tb/axi_txn_shaper_tb.sv
`timescale 1ns/1ps
module axi_txn_shaper_tb;
  localparam int AW = 32, DW = 32;
  localparam int RD_MAX = 2, WR_MAX = 0, ALL_MAX = 5, RD_LAT = 6, WR_LAT = 5, SLOTS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic up_arvalid = 0, up_arready, dn_arvalid, dn_arready = 0;
  logic [AW-1:0] up_araddr = 0, dn_araddr;
  logic [7:0] up_arlen = 0, dn_arlen;
  logic dn_rvalid = 0, dn_rready, dn_rlast = 0, up_rvalid, up_rready = 0, up_rlast;
  logic [DW-1:0] dn_rdata = 0, up_rdata;
  logic [1:0] dn_rresp = 0, up_rresp;
  logic up_awvalid = 0, up_awready, dn_awvalid, dn_awready = 0;
  logic [AW-1:0] up_awaddr = 0, dn_awaddr;
  logic [7:0] up_awlen = 0, dn_awlen;
  logic up_wvalid = 0, up_wready, up_wlast = 0, dn_wvalid, dn_wready = 0, dn_wlast;
  logic [DW-1:0] up_wdata = 0, dn_wdata;
  logic [DW/8-1:0] up_wstrb = '1, dn_wstrb;
  logic dn_bvalid = 0, dn_bready, up_bvalid, up_bready = 0;
  logic [1:0] dn_bresp = 0, up_bresp;

  axi_txn_shaper #(.ADDR_W(AW), .DATA_W(DW), .RD_MAX(RD_MAX), .WR_MAX(WR_MAX),
    .ALL_MAX(ALL_MAX), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .SLOTS(SLOTS)) u_dut (.*);

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  int pa = 0, paw = 0, pwv = 0, prr = 0, pbr = 0, psa = 0, psaw = 0, psw = 0, prv = 0, pbv = 0;

  int ar_acc = 0, r_done = 0, rbeat = 0, aw_acc = 0, w_done = 0, w_started = 0, b_done = 0;
  bit wfirst = 1;
  int rstamp [1024], wst [1024];
  logic [AW-1:0] raddr [1024], waddr [1024];
  bit ar_h, r_h, aw_h, w_h, b_h, prev_arwait;
  logic [AW-1:0] prev_araddr;

  int mwl [1024], mw_h = 0, mw_t = 0, wb = 0;
  logic [AW-1:0] sraddr [1024], swaddr [1024];
  int srlen [1024], st = 0, sh = 0, sbeat = 0, swa = 0, swd = 0, sbb = 0;

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic monitor();
    bit exp_rv, exp_bv, ok_ar;
    ar_h = up_arvalid && up_arready;
    r_h  = up_rvalid && up_rready;
    aw_h = up_awvalid && up_awready;
    w_h  = up_wvalid && up_wready;
    b_h  = up_bvalid && up_bready;
    if (ar_h) chk((ar_acc - r_done + 1) <= RD_MAX, "R1", "pending reads", ar_acc - r_done + 1, RD_MAX);
    if (aw_h) chk((aw_acc - b_done + 1) <= SLOTS, "R2", "pending writes", aw_acc - b_done + 1, SLOTS);
    if (ar_h || aw_h)
      chk((ar_acc - r_done + aw_acc - b_done + int'(ar_h) + int'(aw_h)) <= ALL_MAX, "R3", "pending total",
          ar_acc - r_done + aw_acc - b_done + int'(ar_h) + int'(aw_h), ALL_MAX);
    exp_rv = dn_rvalid && (ar_acc > r_done) && (cyc - rstamp[r_done % 1024] >= RD_LAT + 1);
    chk(up_rvalid == exp_rv, "R4", "up_rvalid", up_rvalid, exp_rv);
    if (up_rvalid)
      chk(up_rdata == raddr[r_done % 1024] + AW'(rbeat), "R8", "rdata", up_rdata, raddr[r_done % 1024] + AW'(rbeat));
    exp_bv = dn_bvalid && (aw_acc > b_done) && (w_started > b_done) && (cyc - wst[b_done % 1024] >= WR_LAT + 1);
    chk(up_bvalid == exp_bv, "R5", "up_bvalid", up_bvalid, exp_bv);
    if (up_bvalid)
      chk(up_bresp == waddr[b_done % 1024][1:0], "R8", "bresp", up_bresp, waddr[b_done % 1024][1:0]);
    chk(up_wready == (dn_wready && aw_acc > w_done), "R6", "up_wready", up_wready, dn_wready && aw_acc > w_done);
    if (prev_arwait) begin
      ok_ar = dn_arvalid && dn_araddr == prev_araddr;
      chk(ok_ar, "R7", "held read address", dn_araddr, prev_araddr);
    end
    if (ar_h) begin rstamp[ar_acc % 1024] = cyc; raddr[ar_acc % 1024] = up_araddr; ar_acc++; end
    if (r_h) begin if (up_rlast) begin r_done++; rbeat = 0; end else rbeat++; end
    if (aw_h) begin waddr[aw_acc % 1024] = up_awaddr; aw_acc++; end
    if (w_h) begin
      if (wfirst) begin wst[w_started % 1024] = cyc; w_started++; end
      wfirst = up_wlast;
      if (up_wlast) w_done++;
    end
    if (b_h) b_done++;
    prev_arwait = dn_arvalid && !dn_arready && up_arvalid;
    prev_araddr = dn_araddr;
    cyc++;
  endtask

  task automatic drive();
    if (ar_h) begin sraddr[st % 1024] = up_araddr; srlen[st % 1024] = int'(up_arlen); st++; end
    if (aw_h) begin swaddr[swa % 1024] = up_awaddr; swa++; end
    if (w_h && up_wlast) swd++;
    if (dn_rvalid && r_h) begin
      if (dn_rlast) begin dn_rvalid = 0; sh++; end
      else begin sbeat++; dn_rdata = sraddr[sh % 1024] + DW'(sbeat); dn_rlast = (sbeat == srlen[sh % 1024]); end
    end
    if (!dn_rvalid && sh != st && pct(prv)) begin
      dn_rvalid = 1; sbeat = 0; dn_rdata = sraddr[sh % 1024]; dn_rlast = (srlen[sh % 1024] == 0);
    end
    if (dn_bvalid && b_h) begin dn_bvalid = 0; sbb++; end
    if (!dn_bvalid && sbb < swa && sbb < swd && pct(pbv)) begin dn_bvalid = 1; dn_bresp = swaddr[sbb % 1024][1:0]; end
    dn_arready = pct(psa); dn_awready = pct(psaw); dn_wready = pct(psw);
    up_rready = pct(prr); up_bready = pct(pbr);
    if (up_arvalid && ar_h) up_arvalid = 0;
    if (!up_arvalid && pct(pa)) begin up_arvalid = 1; up_araddr = $urandom & 32'hffff_fff0; up_arlen = 8'($urandom % 4); end
    if (up_awvalid && aw_h) up_awvalid = 0;
    if (!up_awvalid && pct(paw)) begin
      up_awvalid = 1; up_awaddr = $urandom; up_awlen = 8'($urandom % 4);
      mwl[mw_t % 1024] = int'(up_awlen); mw_t++;
    end
    if (up_wvalid && w_h) begin
      if (up_wlast) begin up_wvalid = 0; mw_h++; end
      else begin wb++; up_wlast = (wb == mwl[mw_h % 1024]); up_wdata = $urandom; end
    end
    if (!up_wvalid && mw_h != mw_t && pct(pwv)) begin
      up_wvalid = 1; wb = 0; up_wlast = (mwl[mw_h % 1024] == 0); up_wdata = $urandom;
    end
  endtask

  task automatic cycle();
    @(negedge clk); monitor();
    @(posedge clk); #1; drive();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    void'($urandom(32'd1234));
    dn_arready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(up_rvalid == 0, "R9", "up_rvalid after reset", up_rvalid, 0);
    chk(up_bvalid == 0, "R9", "up_bvalid after reset", up_bvalid, 0);
    chk(up_wready == 0, "R9", "up_wready after reset", up_wready, 0);
    chk(up_arready == 1, "R9", "up_arready after reset", up_arready, 1);
    @(posedge clk); #1;
    // directed: lone read and lone write against an instant subordinate (R4, R5 exact release)
    psa = 100; psaw = 100; psw = 100; prv = 100; pbv = 100; prr = 100; pbr = 100; pwv = 100;
    pa = 100; paw = 100; cycle(); pa = 0; paw = 0;
    repeat (30) cycle();
    // directed: saturation with no responses (R1, R2, R3)
    prv = 0; pbv = 0; pa = 100; paw = 100;
    repeat (30) cycle();
    @(negedge clk);
    chk((ar_acc - r_done) == RD_MAX, "R1", "saturated reads", ar_acc - r_done, RD_MAX);
    chk((aw_acc - b_done) == ALL_MAX - RD_MAX, "R3", "saturated writes", aw_acc - b_done, ALL_MAX - RD_MAX);
    @(posedge clk); #1;
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      if (i % 500 == 0) begin
        pa = 20 + int'($urandom % 70); paw = 20 + int'($urandom % 70); pwv = 30 + int'($urandom % 70);
        prr = 30 + int'($urandom % 70); pbr = 30 + int'($urandom % 70); psa = 30 + int'($urandom % 70);
        psaw = 30 + int'($urandom % 70); psw = 30 + int'($urandom % 70);
        prv = 10 + int'($urandom % 80); pbv = 10 + int'($urandom % 80);
      end
      cycle();
    end
    // drain
    pa = 0; paw = 0; pwv = 100; prr = 100; pbr = 100; psa = 100; psaw = 100; psw = 100; prv = 100; pbv = 100;
    for (int i = 0; i < 3000; i++) begin
      if (ar_acc == r_done && aw_acc == b_done && !up_arvalid && !up_awvalid && mw_h == mw_t) break;
      cycle();
    end
    chk(ar_acc == r_done, "R8", "reads completed", r_done, ar_acc);
    chk(aw_acc == b_done, "R8", "writes completed", b_done, aw_acc);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end
endmodule